// File: doc/BRIEF.md
# Buffered Synchronous Serial Receiver

This block takes clocked serial data on one data input and collects it into a small buffer of words. The serial clock comes from one of two places. The block can produce it itself, by dividing the system clock by a programmable power of two, and drive it out on `sclk_o`. Or it can take it from an external clock pin, `sclk_i`, which it synchronises to the system clock. Each word is 4 or 8 bits long. Software chooses how many words, from one to eight, make up a burst. When a burst is complete the block raises an interrupt. Software then reads the words back over a simple register bus.

When software is slow to read, the block behaves differently for each clock source. With its own clock it holds the serial clock high until a buffer read arrives. With an external clock it cannot hold off the sender, so it drops the word, stops receiving and flags an overrun. Software can end reception in two ways. It can ask for a stop at the next word boundary, or it can kill reception at once and discard the partial word.

Top module: `ssr_rx_top`

## Requirements
- R1: Bits are sampled on each rising serial clock edge, least significant bit first. In 8-bit mode (CTRL bit 3 = 1) the k-th word of a burst is readable at bus address 8+k, where k counts from 0.
- R2: In 4-bit mode (CTRL bit 3 = 0) each word is four bits long. It reads back as an 8-bit value whose upper nibble is zero.
- R3: CFG bits 2:0 hold N-1, where N is the number of words in a burst. `irq` rises in the cycle after the N-th word is stored. `irq` stays high until any read in the buffer window (addresses 8 to 15).
- R4: When the internal clock is selected (CTRL bit 2 = 0), `sclk_o` sits high while idle. Each half period of `sclk_o` lasts 2^D system clocks, where D is CTRL bits 6:4.
- R5: If a burst is full and unread and the internal clock is selected, `sclk_o` stays high and no new word starts. A read of any buffer address, including one beyond the burst length, lets reception go on.
- R6: When the external clock is selected (CTRL bit 2 = 1), a word that completes while the buffer is full and unread is not stored. When that happens, busy (STATUS bit 0) drops and overrun (STATUS bit 1) is set. Writing 1 to STATUS bit 1 clears the overrun flag.
- R7: Writing CTRL with run (bit 0) = 0 during reception lets the word in progress finish and be stored. No further word starts, and busy drops.
- R8: Writing CTRL with kill (bit 1) = 1 ends reception at once. It clears busy and `irq`, discards the partial word and parks `sclk_o` high.
- R9: A CTRL write that changes the word-length bit clears every buffer word to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a buffer read acknowledges data) |
| bus_addr | input | 4 | Register address: 0 CTRL, 1 CFG, 2 STATUS, 8-15 buffer |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| sclk_i | input | 1 | External serial clock |
| sclk_o | output | 1 | Internally generated serial clock |
| sdi | input | 1 | Serial data input |
| irq | output | 1 | Buffer-full interrupt |

## Verification
The bench runs full bursts with both clock sources and both word lengths, including the largest burst. A mistake in bit order, nibble placement or the wrap at the burst count shows up there as wrong read-back words or a missing interrupt. Several tests target the flow-control corners. In the stall test, a receiver that kept clocking while the buffer was full would move the serial bit index on. In the overrun test, a receiver that overwrote the first word instead of dropping the new one would return the wrong word 0. A separate test reads an address beyond the burst, and a design that ignored that read would stay stalled. The graceful-stop test checks that exactly two words' worth of clock falls occur, which catches a design that stops too early or starts a third word. The kill test and the word-length change test catch state that survives those writes.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 8;
  localparam logic [AW-1:0] A_CTRL = 4'd0;
  localparam logic [AW-1:0] A_CFG  = 4'd1;
  localparam logic [AW-1:0] A_STAT = 4'd2;
  localparam int unsigned C_RUN  = 0;
  localparam int unsigned C_KILL = 1;
  localparam int unsigned C_EXT  = 2;
  localparam int unsigned C_WIDE = 3;
  localparam int unsigned C_DIVL = 4;
  localparam int unsigned S_BUSY = 0;
  localparam int unsigned S_OVR  = 1;
  localparam int unsigned S_FULL = 2;
endpackage

// File: rtl/ssr_clkgen.sv
module ssr_clkgen #(
  parameter int unsigned DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_int,
  input  logic             ext_sel,
  input  logic [DIV_W-1:0] div,
  input  logic             sclk_i,
  output logic             sclk_o,
  output logic             tick
);
  localparam int unsigned CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_n, lim;
  logic             sclk_q, sclk_n;
  logic [2:0]       sync_q, sync_n;
  logic             int_tick, ext_tick;

  always_comb begin
    lim    = CNT_W'((32'd1 << div) - 32'd1);
    cnt_n  = cnt_q;
    sclk_n = sclk_q;
    if (!en_int) begin
      cnt_n  = '0;
      sclk_n = 1'b1;
    end else if (cnt_q == lim) begin
      cnt_n  = '0;
      sclk_n = ~sclk_q;
    end else begin
      cnt_n  = cnt_q + 1'b1;
    end
    sync_n   = {sync_q[1:0], sclk_i};
    int_tick = en_int && (cnt_q == lim) && !sclk_q;
    ext_tick = sync_q[1] && !sync_q[2];
    tick     = ext_sel ? ext_tick : int_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
      sync_q <= 3'b111;
    end else begin
      cnt_q  <= cnt_n;
      sclk_q <= sclk_n;
      sync_q <= sync_n;
    end
  end

  assign sclk_o = sclk_q;
endmodule

// File: rtl/ssr_shift.sv
module ssr_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic         sdi,
  input  logic         wide,
  output logic         done,
  output logic         gap,
  output logic [W-1:0] word
);
  localparam int unsigned CW   = $clog2(W);
  localparam int unsigned HALF = W / 2;

  logic [CW-1:0] cnt_q, cnt_n, last;
  logic [W-1:0]  sh_q, sh_n, sh_in;

  always_comb begin
    last  = wide ? CW'(W - 1) : CW'(HALF - 1);
    sh_in = {sdi, sh_q[W-1:1]};
    cnt_n = cnt_q;
    sh_n  = sh_q;
    done  = 1'b0;
    if (clr) begin
      cnt_n = '0;
    end else if (tick) begin
      sh_n = sh_in;
      if (cnt_q == last) begin
        cnt_n = '0;
        done  = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
    word = wide ? sh_in : (sh_in >> HALF);
    gap  = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
    end
  end
endmodule

// File: rtl/ssr_buf.sv
module ssr_buf #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 8,
  parameter int unsigned IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_all,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem_q [DEPTH];
  logic [W-1:0] mem_n [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_comb begin
      mem_n[g] = mem_q[g];
      if (clr_all)                            mem_n[g] = '0;
      else if (wr_en && (wr_idx == IW'(g)))   mem_n[g] = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[g] <= '0;
      else        mem_q[g] <= mem_n[g];
    end
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/ssr_rx_top.sv
module ssr_rx_top
  import ssr_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DIV_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          sclk_i,
  output logic          sclk_o,
  input  logic          sdi,
  output logic          irq
);
  localparam int unsigned IW = $clog2(DEPTH);

  logic [1:0]       rsync_q;
  logic             rst_s;
  logic             run_q, run_n, ext_q, ext_n, wide_q, wide_n;
  logic [DIV_W-1:0] div_q, div_n;
  logic [IW-1:0]    wcnt_q, wcnt_n, wptr_q, wptr_n;
  logic             busy_q, busy_n, ovr_q, ovr_n, full_q, full_n;
  logic             wr_ctrl, wr_cfg, wr_stat, rd_buf, kill, start, mode_chg;
  logic             en_int, tick, rx_tick, w_done, gap, overrun, store;
  logic [DW-1:0]    word, buf_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  always_comb begin
    wr_ctrl  = bus_sel && bus_wr && (bus_addr == A_CTRL);
    wr_cfg   = bus_sel && bus_wr && (bus_addr == A_CFG);
    wr_stat  = bus_sel && bus_wr && (bus_addr == A_STAT);
    rd_buf   = bus_sel && bus_rd && bus_addr[AW-1];
    kill     = wr_ctrl && bus_wdata[C_KILL];
    start    = wr_ctrl && bus_wdata[C_RUN] && !bus_wdata[C_KILL] && !busy_q;
    mode_chg = wr_ctrl && (bus_wdata[C_WIDE] != wide_q);
    en_int   = busy_q && !ext_q && !(gap && (full_q || !run_q));
    rx_tick  = tick && busy_q;
    overrun  = w_done && ext_q && full_q;
    store    = w_done && !overrun;

    run_n  = run_q;  ext_n = ext_q;  wide_n = wide_q;  div_n = div_q;
    wcnt_n = wcnt_q;
    if (wr_ctrl) begin
      run_n  = bus_wdata[C_RUN] && !bus_wdata[C_KILL];
      ext_n  = bus_wdata[C_EXT];
      wide_n = bus_wdata[C_WIDE];
      div_n  = bus_wdata[C_DIVL +: DIV_W];
    end
    if (wr_cfg) wcnt_n = bus_wdata[IW-1:0];

    busy_n = busy_q;
    if (kill)                         busy_n = 1'b0;
    else if (start)                   busy_n = 1'b1;
    else if (overrun)                 busy_n = 1'b0;
    else if (busy_q && !run_q && gap) busy_n = 1'b0;

    ovr_n = ovr_q;
    if (overrun)                           ovr_n = 1'b1;
    else if (wr_stat && bus_wdata[S_OVR])  ovr_n = 1'b0;

    full_n = full_q;
    if (kill || start)                      full_n = 1'b0;
    else if (store && (wptr_q == wcnt_q))   full_n = 1'b1;
    else if (rd_buf)                        full_n = 1'b0;

    wptr_n = wptr_q;
    if (kill || start || mode_chg) wptr_n = '0;
    else if (store)                wptr_n = (wptr_q == wcnt_q) ? '0 : wptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      run_q <= 1'b0;  ext_q <= 1'b0;  wide_q <= 1'b1;  div_q <= '0;
      wcnt_q <= '0;   wptr_q <= '0;
      busy_q <= 1'b0; ovr_q <= 1'b0;  full_q <= 1'b0;
    end else begin
      run_q <= run_n;  ext_q <= ext_n;  wide_q <= wide_n;  div_q <= div_n;
      wcnt_q <= wcnt_n; wptr_q <= wptr_n;
      busy_q <= busy_n; ovr_q <= ovr_n; full_q <= full_n;
    end
  end

  ssr_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_s), .en_int(en_int), .ext_sel(ext_q), .div(div_q),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .tick(tick)
  );

  ssr_shift #(.W(DW)) u_shift (
    .clk(clk), .rst_n(rst_s), .clr(!busy_q || kill), .tick(rx_tick), .sdi(sdi),
    .wide(wide_q), .done(w_done), .gap(gap), .word(word)
  );

  ssr_buf #(.DEPTH(DEPTH), .W(DW)) u_buf (
    .clk(clk), .rst_n(rst_s), .clr_all(mode_chg), .wr_en(store), .wr_idx(wptr_q),
    .wr_data(word), .rd_idx(bus_addr[IW-1:0]), .rd_data(buf_rd)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[AW-1]) bus_rdata = buf_rd;
    else if (bus_addr == A_CTRL) begin
      bus_rdata[C_RUN]  = run_q;
      bus_rdata[C_EXT]  = ext_q;
      bus_rdata[C_WIDE] = wide_q;
      bus_rdata[C_DIVL +: DIV_W] = div_q;
    end else if (bus_addr == A_CFG) bus_rdata[IW-1:0] = wcnt_q;
    else if (bus_addr == A_STAT) begin
      bus_rdata[S_BUSY] = busy_q;
      bus_rdata[S_OVR]  = ovr_q;
      bus_rdata[S_FULL] = full_q;
    end
  end

  assign irq = full_q;
endmodule

// File: rtl/ssr_rx_chk.sv
module ssr_rx_chk #(
  parameter int unsigned IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          ext,
  input logic          full,
  input logic          gap,
  input logic          ovr,
  input logic          kill,
  input logic          sclk_o,
  input logic [IW-1:0] wptr
);
  // R4: serial clock parks high whenever reception is idle
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> sclk_o);

  // R5: full and unread at a word boundary holds the internal clock high
  p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ext && full && gap && sclk_o) |=> sclk_o);

  // R6: an overrun leaves the receiver stopped
  p_ovr_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> !busy);

  // R8: kill clears activity and the interrupt in the next cycle
  p_kill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!busy && !full));

  // R3: the buffer becomes full exactly when the write index wraps
  p_full_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> (wptr == '0));
endmodule

bind ssr_rx_top ssr_rx_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_s), .busy(busy_q), .ext(ext_q), .full(full_q), .gap(gap),
  .ovr(ovr_q), .kill(kill), .sclk_o(sclk_o), .wptr(wptr_q)
);

// File: tb/tb_ssr_rx_top.sv
module tb_ssr_rx_top;
  logic       clk, rst_n, bus_sel, bus_wr, bus_rd, sclk_i, sdi, drive_int;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, rd;
  wire        sclk_o, irq;
  int checks, fails, cyc, tx_idx, tx_n, t0, t1;
  logic tx [0:255];

  // {ext, wide, count-1[2:0], div[2:0], seed[7:0]}
  localparam logic [15:0] VEC [4] = '{16'h51A5, 16'h383C, 16'hD85E, 16'h8809};

  ssr_rx_top dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sdi(sdi), .irq(irq));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  always @(negedge sclk_o) if (drive_int) begin
    sdi = tx[tx_idx & 255];
    tx_idx++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic br(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0; bus_rd = 0;
  endtask

  function automatic logic [7:0] cw(input logic run, kill, ext, wide, input logic [2:0] dv);
    return {1'b0, dv, wide, ext, kill, run};
  endfunction

  task automatic load(input logic [7:0] w, input int len);
    for (int b = 0; b < len; b++) begin tx[tx_n] = w[b]; tx_n++; end
  endtask

  task automatic ext_send(input logic [7:0] w, input int len);
    for (int b = 0; b < len; b++) begin
      sdi = w[b];
      repeat (6) @(negedge clk); sclk_i = 0;
      repeat (6) @(negedge clk); sclk_i = 1;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 20000 && !irq; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      br(4'd2, rd);
      if (!rd[0]) break;
    end
  endtask

  task automatic clear_tx();
    tx_n = 0; tx_idx = 0;
    for (int i = 0; i < 256; i++) tx[i] = 1'b0;
  endtask

  initial begin
    checks = 0; fails = 0; cyc = 0;
    bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    sclk_i = 1; sdi = 0; drive_int = 0; rst_n = 0;
    clear_tx();
    repeat (3) @(negedge clk); rst_n = 1; repeat (3) @(negedge clk);

    // reset state
    check("R4 reset sclk_o idle", sclk_o, 1);
    check("R3 reset irq", irq, 0);
    br(4'd2, rd); check("R6 reset status", rd, 0);

    // table of bursts
    foreach (VEC[e]) begin
      logic ext, wide; logic [2:0] cm, dv; logic [7:0] seed, w, mask; int len;
      {ext, wide, cm, dv, seed} = VEC[e];
      mask = wide ? 8'hFF : 8'h0F; len = wide ? 8 : 4;
      clear_tx();
      bw(4'd0, cw(0, 0, ext, wide, dv));
      bw(4'd1, {5'd0, cm});
      for (int i = 0; i <= int'(cm); i++) load((seed + 8'(i * 59)) & mask, len);
      drive_int = !ext;
      bw(4'd0, cw(1, 0, ext, wide, dv));
      if (ext) for (int i = 0; i <= int'(cm); i++) ext_send((seed + 8'(i * 59)) & mask, len);
      wait_irq();
      check("R3 irq after burst", irq, 1);
      bw(4'd0, cw(0, 0, ext, wide, dv));
      wait_idle();
      check("R7 busy clear after stop", rd[0], 0);
      for (int i = 0; i <= int'(cm); i++) begin
        w = (seed + 8'(i * 59)) & mask;
        br(4'(8 + i), rd);
        check(wide ? "R1 word" : "R2 nibble word", rd, w);
      end
      check("R3 irq cleared by read", irq, 0);
      drive_int = 0;
    end

    // R4: half period with divider 2
    clear_tx(); drive_int = 1;
    bw(4'd0, cw(0, 0, 0, 1, 3'd2)); bw(4'd1, 8'd0);
    bw(4'd0, cw(1, 0, 0, 1, 3'd2));
    @(negedge sclk_o); t0 = cyc;
    @(posedge sclk_o); t1 = cyc;
    check("R4 half period cycles", t1 - t0, 4);

    // R8: kill mid word
    repeat (3) @(posedge sclk_o);
    bw(4'd0, cw(0, 1, 0, 1, 3'd2));
    t0 = tx_idx;
    br(4'd2, rd); check("R8 status after kill", rd, 0);
    check("R8 sclk_o parked", sclk_o, 1);
    repeat (40) @(negedge clk);
    check("R8 no further clocks", tx_idx, t0);

    // R5: automatic wait and release by unused buffer address
    clear_tx();
    bw(4'd0, cw(1, 0, 0, 1, 3'd0));
    wait_irq();
    check("R5 irq before wait", irq, 1);
    t0 = tx_idx;
    repeat (100) @(negedge clk);
    check("R5 clock held while full", tx_idx, t0);
    check("R5 sclk_o high in wait", sclk_o, 1);
    br(4'd15, rd);
    repeat (20) @(negedge clk);
    check("R5 released by unused address", tx_idx > t0, 1);
    bw(4'd0, cw(0, 1, 0, 1, 3'd0));
    drive_int = 0;

    // R6: external overrun
    bw(4'd1, 8'd0);
    bw(4'd0, cw(1, 0, 1, 1, 3'd0));
    ext_send(8'h4D, 8);
    wait_irq();
    ext_send(8'hB2, 8);
    repeat (5) @(negedge clk);
    br(4'd2, rd); check("R6 status overrun", rd, 8'h06);
    br(4'd8, rd); check("R6 first word kept", rd, 8'h4D);
    bw(4'd2, 8'h02);
    br(4'd2, rd); check("R6 overrun cleared", rd[1], 0);

    // R9: word length change clears buffer
    bw(4'd0, cw(0, 0, 1, 0, 3'd0));
    br(4'd8, rd); check("R9 buffer cleared", rd, 0);

    // R7: graceful stop finishes current word
    clear_tx(); load(8'h11, 8); load(8'h99, 8);
    for (int i = 0; i < 8; i++) load(8'hFF, 8);
    bw(4'd0, cw(0, 0, 0, 1, 3'd2)); bw(4'd1, 8'd7);
    drive_int = 1;
    bw(4'd0, cw(1, 0, 0, 1, 3'd2));
    for (int i = 0; i < 20000 && tx_idx < 12; i++) @(negedge clk);
    bw(4'd0, cw(0, 0, 0, 1, 3'd2));
    wait_idle();
    check("R7 busy dropped", rd[0], 0);
    check("R7 exactly two words clocked", tx_idx, 16);
    br(4'd9, rd); check("R7 final word readable", rd, 8'h99);
    br(4'd8, rd); check("R7 first word", rd, 8'h11);
    check("R7 no irq on partial burst", irq, 0);
    drive_int = 0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule